// File: doc/BRIEF.md
# Format-Tracking Register Bank

This block is a small byte-wide control register file for a clock generator with several video outputs. Each output has a format selector register and a derived 4-bit code register. Writing a format selector also loads the matching derived code from a built-in format table. A one-cycle custom-timing pulse for an output overwrites that output's code with the marker value 14. The marker shows that the output no longer runs a standard format. A later write to the format selector restores the table value.

The bank also holds a 10-bit input divider, split across a high register (2 bits) and a low register (8 bits). A control bit turns on automatic format detection. While it is set, the divider is loaded from the detected input format and host writes to the divider are dropped. While it is clear, the host owns the divider and detection reports are ignored.

Host access is a request channel and a response channel, both valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Writes produce no response. Each accepted read produces one response, which stays valid and unchanged until the edge where `rsp_ready` is high. While a response waits, the bank does not accept new requests. The parameter `NUM_OUT` may be from 1 to 8.

Top module: `fmtbank_top`

## Requirements
- R1: After reset, the format selector of output i (address 0x00+i) reads 7-i, and the code of output i (address 0x08+i) reads the table value for that format: 5 for output 0 and 6 for output 1.
- R2: After reset, the divider reads high = 0x00 (address 0x10) and low = 0x01 (address 0x11), and the control register (address 0x12, bit 0 = automatic detection) reads 0x00.
- R3: A write of format f (bits 4:0) to the selector of output i loads that output's code with 12-f, for f from 0 to 12.
- R4: A format from 13 to 31 loads code 14.
- R5: A custom pulse on `custom_mark[i]` sets code i to 14 at the next edge, and leaves the other outputs' codes unchanged.
- R6: After a custom pulse, a later selector write restores the table code. If a selector write and a custom pulse for the same output land on the same edge, the selector write wins.
- R7: Reserved bits read as zero: selector bits 7:5, code bits 7:4, divider-high bits 7:2, and control bits 7:1.
- R8: With automatic detection off, host writes set the divider high bits (from wdata 1:0) and the divider low byte.
- R9: With automatic detection off, a `det_valid` report leaves the divider unchanged.
- R10: With automatic detection on, host writes to the divider are ignored. A report of a detected format f from 0 to 12 loads the divider with 64*f+1. A report of an unknown format (13 to 31) leaves the divider unchanged.
- R11: An unmapped address reads 0x00, and a write to it changes no register.
- R12: A read response appears one cycle after acceptance. It is held stable while `rsp_ready` is low, and `req_ready` is low for as long as a response waits.
- R13: The host may write a code register directly. Its low 4 bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 8 | Read data |
| custom_mark | input | NUM_OUT | One-cycle custom-timing pulse per output |
| det_valid | input | 1 | Detected-format report strobe |
| det_format | input | 5 | Detected input format index |

## Verification
A wrong code or divider state is visible only through a read. The earliest point it can show is the response one cycle after a read is accepted. The bench therefore reads back every affected register, and unaffected neighbours, straight after each write, pulse or detection report. A wrong decision about which source has priority (the same-edge selector write against a pulse, or the auto bit gating host writes against detection) shows as a single wrong read value. A wrong handshake shows within the same cycle, as a dropped response or as `req_ready` high while a response waits.

// File: rtl/fmtbank_pkg.sv
package fmtbank_pkg;
  localparam int FMT_W   = 5;
  localparam int CODE_W  = 4;
  localparam int DIV_W   = 10;
  localparam int BYTE_W  = 8;
  localparam int NUM_STD = 13;
  localparam logic [CODE_W-1:0] MARK_CODE = CODE_W'(14);

  // derived output code for a format index
  function automatic logic [CODE_W-1:0] fmt_to_code(input logic [FMT_W-1:0] f);
    if (f < FMT_W'(NUM_STD))
      return CODE_W'(NUM_STD - 1 - int'(f));
    return MARK_CODE;
  endfunction

  // divider value for a detected format index
  function automatic logic [DIV_W-1:0] fmt_to_div(input logic [FMT_W-1:0] f);
    return DIV_W'((int'(f) * 64) + 1);
  endfunction
endpackage

// File: rtl/fmtbank_slot.sv
module fmtbank_slot
  import fmtbank_pkg::*;
#(
  parameter int RESET_FMT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_we,
  input  logic              code_we,
  input  logic              custom_mark,
  input  logic [FMT_W-1:0]  wdata,
  output logic [FMT_W-1:0]  fmt_q,
  output logic [CODE_W-1:0] code_q
);
  localparam logic [FMT_W-1:0]  RST_FMT  = FMT_W'(RESET_FMT);
  localparam logic [CODE_W-1:0] RST_CODE = fmt_to_code(RST_FMT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q  <= RST_FMT;
      code_q <= RST_CODE;
    end else begin
      if (fmt_we)
        fmt_q <= wdata;
      // selector write outranks the custom marker, which outranks a direct write
      if (fmt_we)
        code_q <= fmt_to_code(wdata);
      else if (custom_mark)
        code_q <= MARK_CODE;
      else if (code_we)
        code_q <= wdata[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/fmtbank_divider.sv
module fmtbank_divider
  import fmtbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_on,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              det_valid,
  input  logic [FMT_W-1:0]  det_format,
  output logic [DIV_W-1:0]  div_q
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic det_known;
  assign det_known = det_format < FMT_W'(NUM_STD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
    end else if (auto_on) begin
      if (det_valid && det_known)
        div_q <= fmt_to_div(det_format);
    end else begin
      if (hi_we)
        div_q[DIV_W-1:BYTE_W] <= wdata[HI_W-1:0];
      if (lo_we)
        div_q[BYTE_W-1:0] <= wdata;
    end
  end
endmodule

// File: rtl/fmtbank_host_port.sv
module fmtbank_host_port
  import fmtbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  input  logic [BYTE_W-1:0] rd_mux,
  output logic              wr_en,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data
);
  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fmtbank_top.sv
module fmtbank_top
  import fmtbank_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BYTE_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BYTE_W-1:0]  rsp_data,
  input  logic [NUM_OUT-1:0] custom_mark,
  input  logic               det_valid,
  input  logic [FMT_W-1:0]   det_format
);
  localparam int FMT_BASE  = 8'h00;
  localparam int CODE_BASE = 8'h08;
  localparam int DIV_HI_A  = 8'h10;
  localparam int DIV_LO_A  = 8'h11;
  localparam int CTRL_A    = 8'h12;

  logic                      wr_en;
  logic [NUM_OUT-1:0]        fmt_we;
  logic [NUM_OUT-1:0]        code_we;
  logic                      div_hi_we;
  logic                      div_lo_we;
  logic                      ctrl_we;
  logic                      auto_on;
  logic [FMT_W-1:0]          fmt_q  [NUM_OUT];
  logic [CODE_W-1:0]         code_q [NUM_OUT];
  logic [NUM_OUT*CODE_W-1:0] code_flat;
  logic [DIV_W-1:0]          div_q;
  logic [BYTE_W-1:0]         rd_mux;

  // write decode
  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) begin
      fmt_we[i]  = wr_en && (req_addr == ADDR_W'(FMT_BASE + i));
      code_we[i] = wr_en && (req_addr == ADDR_W'(CODE_BASE + i));
    end
  end
  assign div_hi_we = wr_en && (req_addr == ADDR_W'(DIV_HI_A));
  assign div_lo_we = wr_en && (req_addr == ADDR_W'(DIV_LO_A));
  assign ctrl_we   = wr_en && (req_addr == ADDR_W'(CTRL_A));

  always_ff @(posedge clk) begin
    if (!rst_n)
      auto_on <= 1'b0;
    else if (ctrl_we)
      auto_on <= req_wdata[0];
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_slot
    fmtbank_slot #(.RESET_FMT(7 - g)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt_we     (fmt_we[g]),
      .code_we    (code_we[g]),
      .custom_mark(custom_mark[g]),
      .wdata      (req_wdata[FMT_W-1:0]),
      .fmt_q      (fmt_q[g]),
      .code_q     (code_q[g])
    );
    assign code_flat[g*CODE_W +: CODE_W] = code_q[g];
  end

  fmtbank_divider u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_on   (auto_on),
    .hi_we     (div_hi_we),
    .lo_we     (div_lo_we),
    .wdata     (req_wdata),
    .det_valid (det_valid),
    .det_format(det_format),
    .div_q     (div_q)
  );

  // read mux, unmapped addresses give zero
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (req_addr == ADDR_W'(FMT_BASE + i))
        rd_mux = BYTE_W'(fmt_q[i]);
      if (req_addr == ADDR_W'(CODE_BASE + i))
        rd_mux = BYTE_W'(code_q[i]);
    end
    if (req_addr == ADDR_W'(DIV_HI_A))
      rd_mux = BYTE_W'(div_q[DIV_W-1:BYTE_W]);
    if (req_addr == ADDR_W'(DIV_LO_A))
      rd_mux = div_q[BYTE_W-1:0];
    if (req_addr == ADDR_W'(CTRL_A))
      rd_mux = BYTE_W'(auto_on);
  end

  fmtbank_host_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .rd_mux   (rd_mux),
    .wr_en    (wr_en),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data)
  );
endmodule

// File: rtl/fmtbank_checks.sv
module fmtbank_checks
  import fmtbank_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_OUT-1:0]        custom_mark,
  input logic [NUM_OUT-1:0]        fmt_we,
  input logic [NUM_OUT*CODE_W-1:0] code_flat,
  input logic                      auto_on,
  input logic                      det_valid,
  input logic                      div_hi_we,
  input logic                      div_lo_we,
  input logic [DIV_W-1:0]          div_q,
  input logic                      req_ready,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [BYTE_W-1:0]         rsp_data
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    // R5: a pulse without a selector write leaves the marker
    p_mark_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      custom_mark[g] && !fmt_we[g] |=> code_flat[g*CODE_W +: CODE_W] == MARK_CODE);
  end

  // R9: detection has no effect when auto mode is off
  p_det_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_on && !div_hi_we && !div_lo_we |=> $stable(div_q));

  // R10: only a detection report can move the divider in auto mode
  p_div_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    auto_on && !det_valid |=> $stable(div_q));

  // R12: a waiting response is held
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R12: no acceptance while a response waits
  p_backpressure_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

bind fmtbank_top fmtbank_checks #(.NUM_OUT(NUM_OUT)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .custom_mark(custom_mark),
  .fmt_we     (fmt_we),
  .code_flat  (code_flat),
  .auto_on    (auto_on),
  .det_valid  (det_valid),
  .div_hi_we  (div_hi_we),
  .div_lo_we  (div_lo_we),
  .div_q      (div_q),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data)
);

// File: tb/fmtbank_top_test.sv
module fmtbank_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic [1:0] custom_mark = '0;
  logic       det_valid = 1'b0;
  logic [4:0] det_format = '0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  fmtbank_top #(.NUM_OUT(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .custom_mark(custom_mark), .det_valid(det_valid), .det_format(det_format)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: each negedge with valid&ready is one transfer at the next edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL unexpected response: actual 0x%02h expected none", rsp_data);
      end else begin
        check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  task automatic issue(bit wr, logic [7:0] a, logic [7:0] d, logic [1:0] pulse);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    custom_mark = pulse;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; custom_mark = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    issue(1'b1, a, d, 2'b00);
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    issue(1'b0, a, 8'h00, 2'b00);
  endtask

  task automatic pulse(logic [1:0] m);
    @(negedge clk); custom_mark = m;
    @(negedge clk); custom_mark = '0;
  endtask

  task automatic detect(logic [4:0] f);
    @(negedge clk); det_valid = 1'b1; det_format = f;
    @(negedge clk); det_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tests++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 reset handshake: actual %b/%b expected 0/1", rsp_valid, req_ready);
    end
    // R1 and R2 reset values
    rd(8'h00, 8'h07, "R1 fmt0");
    rd(8'h01, 8'h06, "R1 fmt1");
    rd(8'h08, 8'h05, "R1 code0");
    rd(8'h09, 8'h06, "R1 code1");
    rd(8'h10, 8'h00, "R2 div hi");
    rd(8'h11, 8'h01, "R2 div lo");
    rd(8'h12, 8'h00, "R2 ctrl");
    // R5 marker on one output only
    pulse(2'b01);
    rd(8'h08, 8'h0E, "R5 code0 marked");
    rd(8'h09, 8'h06, "R5 code1 untouched");
    // R3 and R6 restore
    wr(8'h00, 8'h03);
    rd(8'h08, 8'h09, "R6 R3 code0 restored");
    rd(8'h00, 8'h03, "R3 fmt0");
    // R6 same-edge write beats pulse
    issue(1'b1, 8'h01, 8'h02, 2'b10);
    rd(8'h09, 8'h0A, "R6 same edge");
    // R4 and R7: unknown format, reserved bits
    wr(8'h01, 8'hF5);
    rd(8'h01, 8'h15, "R7 fmt1 masked");
    rd(8'h09, 8'h0E, "R4 code1 unknown");
    wr(8'h01, 8'h0C);
    rd(8'h09, 8'h00, "R3 fmt 12");
    // R13 direct code write
    wr(8'h08, 8'hA7);
    rd(8'h08, 8'h07, "R13 R7 code0 direct");
    // R8 host divider
    wr(8'h10, 8'hFF);
    wr(8'h11, 8'h5A);
    rd(8'h10, 8'h03, "R8 R7 div hi");
    rd(8'h11, 8'h5A, "R8 div lo");
    // R9 detection ignored
    detect(5'd5);
    rd(8'h10, 8'h03, "R9 div hi");
    rd(8'h11, 8'h5A, "R9 div lo");
    // R10 auto mode
    wr(8'h12, 8'hFF);
    rd(8'h12, 8'h01, "R7 ctrl masked");
    wr(8'h10, 8'h00);
    wr(8'h11, 8'h00);
    rd(8'h10, 8'h03, "R10 hi write ignored");
    rd(8'h11, 8'h5A, "R10 lo write ignored");
    detect(5'd5);
    rd(8'h10, 8'h01, "R10 det 5 hi");
    rd(8'h11, 8'h41, "R10 det 5 lo");
    detect(5'd12);
    rd(8'h10, 8'h03, "R10 det 12 hi");
    rd(8'h11, 8'h01, "R10 det 12 lo");
    detect(5'd20);
    rd(8'h10, 8'h03, "R10 unknown hi");
    rd(8'h11, 8'h01, "R10 unknown lo");
    // R11 unmapped
    wr(8'h20, 8'hFF);
    wr(8'h02, 8'hFF);
    rd(8'h20, 8'h00, "R11 read 0x20");
    rd(8'h02, 8'h00, "R11 read 0x02");
    rd(8'h00, 8'h03, "R11 fmt0 intact");
    rd(8'h11, 8'h01, "R11 div intact");
    // R12 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    rd(8'h00, 8'h03, "R12 held read");
    for (int k = 0; k < 3; k++) begin
      tests++;
      if (rsp_valid !== 1'b1 || req_ready !== 1'b0 || rsp_data !== 8'h03) begin
        fails++;
        $display("FAIL R12 hold: actual v=%b r=%b d=0x%02h expected v=1 r=0 d=0x03",
                 rsp_valid, req_ready, rsp_data);
      end
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R12 responses: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule